// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment-Derived Upper Results

This block is a purely combinational binary adder. It takes two operands and a carry input and returns their sum and a carry output. The operand width is 16 bits by default and can be set to 32, 64 or 128 bits. The operand bits are cut into groups, and the groups widen toward the most significant end. The lowest group is a plain ripple-carry stage fed by the external carry input.

Every higher group ripples its own bits once, assuming no incoming carry. The result for an incoming carry of one is formed by adding one to that value. The value is the group sum with the group carry-out on top, and the +1 is done by a small increment circuit, not by a second ripple adder. A two-way selector picks between the two results. Its select input is the carry leaving the group below, so the slow carry path crosses one selector per group rather than one full adder per bit.

The block is meant to sit in a datapath where a registered stage surrounds it. It holds no state and needs no clock.

Top module: `csa_sqrt_adder`

## Requirements
- R1: For every operand pair and carry input, the value {cout, sum} equals a + b + cin computed at WIDTH+1 bits, for any WIDTH of 2 or more.
- R2: The groups are 2, 2, 3, 4, 5 bits wide starting from bit 0, giving boundaries at bits 2, 4, 7 and 11 for 16 bits. Wider builds add one bit per further group and cut the last group short to fit. A carry that ripples exactly up to any boundary gives the correct total.
- R3: The lowest group (bits 1:0) adds its operand bits together with the external cin directly, with no selection step.
- R4: When the carry into an upper group is 0, that group's sum bits and carry-out are its own ripple result computed with a zero carry-in.
- R5: When the carry into an upper group is 1, that group's sum bits and carry-out are the (group width + 1)-bit value {ripple carry-out, ripple sum} plus one. An all-ones group sum therefore wraps to zero with carry-out 1.
- R6: cout is the carry leaving the most significant group. All-ones plus a carry input of 1 gives sum 0 and cout 1.
- R7: The block has no clock and no storage. Both outputs follow the inputs within the same cycle in which the inputs change.
- R8: Zero operands with cin 0 give sum 0 and cout 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
Both outputs are combinational, so every result is due in the same cycle its operands are applied. It has no register latency to count. The driver sets the operands one time unit after a rising edge and queues the expected total. The monitor takes the result from the queue and compares it at the next falling edge, after the operands have settled and before the next change. The stimulus mixes random operands, all-zero, all-ones and alternating patterns, and operands whose carry chain stops exactly at each group boundary.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Select encoding of a group multiplexer: the incoming carry value
    typedef enum logic {
        SEL_PLAIN = 1'b0,
        SEL_INCR  = 1'b1
    } csa_sel_e;

    localparam int FIRST_GRP_BITS = 2;

    // Nominal width of group k before truncation
    function automatic int grp_nominal(input int k);
        return (k < 2) ? FIRST_GRP_BITS : k + 1;
    endfunction

    // Least significant bit of group k
    function automatic int grp_lsb(input int k);
        int acc;
        acc = 0;
        for (int i = 0; i < k; i++) acc += grp_nominal(i);
        return acc;
    endfunction

    // Actual width of group k inside a WIDTH-bit adder
    function automatic int grp_width(input int k, input int width);
        int rem;
        rem = width - grp_lsb(k);
        return (grp_nominal(k) < rem) ? grp_nominal(k) : rem;
    endfunction

    // Number of groups needed to cover WIDTH bits
    function automatic int grp_count(input int width);
        int n;
        n = 0;
        while (grp_lsb(n) < width) n++;
        return n;
    endfunction

endpackage

// File: rtl/csa_rca.sv
module csa_rca #(
    parameter int N = 2
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         c_in,
    output logic [N-1:0] s_out,
    output logic         c_out
);
    logic [N:0] chain;

    assign chain[0] = c_in;

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic p_bit;
            assign p_bit       = op_a[i] ^ op_b[i];
            assign s_out[i]    = p_bit ^ chain[i];
            assign chain[i+1]  = (op_a[i] & op_b[i]) | (p_bit & chain[i]);
        end
    endgenerate

    assign c_out = chain[N];
endmodule

// File: rtl/csa_bec.sv
module csa_bec #(
    parameter int N = 2
) (
    input  logic [N:0] val_in,
    output logic [N:0] val_out
);
    // all_low[i] is the AND of every input bit below i
    logic [N:0] all_low;

    assign all_low[0] = 1'b1;
    assign val_out[0] = ~val_in[0];

    generate
        for (genvar i = 1; i <= N; i++) begin : g_inc
            assign all_low[i] = all_low[i-1] & val_in[i-1];
            assign val_out[i] = val_in[i] ^ all_low[i];
        end
    endgenerate
endmodule

// File: rtl/csa_sel_mux.sv
module csa_sel_mux #(
    parameter int N = 2
) (
    input  logic [N:0]         d_plain,
    input  logic [N:0]         d_incr,
    input  csa_pkg::csa_sel_e  sel,
    output logic [N:0]         y
);
    always_comb begin
        unique case (sel)
            csa_pkg::SEL_INCR:  y = d_incr;
            default:            y = d_plain;
        endcase
    end
endmodule

// File: rtl/csa_group.sv
module csa_group #(
    parameter int N = 3
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         c_sel,
    output logic [N-1:0] s_out,
    output logic         c_out,
    output logic [N-1:0] raw_s,
    output logic         raw_c
);
    logic [N:0] plain_v;
    logic [N:0] incr_v;
    logic [N:0] pick_v;
    csa_pkg::csa_sel_e sel_e;

    csa_rca #(.N(N)) u_rca (
        .op_a  (op_a),
        .op_b  (op_b),
        .c_in  (1'b0),
        .s_out (raw_s),
        .c_out (raw_c)
    );

    assign plain_v = {raw_c, raw_s};

    csa_bec #(.N(N)) u_bec (
        .val_in  (plain_v),
        .val_out (incr_v)
    );

    assign sel_e = csa_pkg::csa_sel_e'(c_sel);

    csa_sel_mux #(.N(N)) u_mux (
        .d_plain (plain_v),
        .d_incr  (incr_v),
        .sel     (sel_e),
        .y       (pick_v)
    );

    assign s_out = pick_v[N-1:0];
    assign c_out = pick_v[N];
endmodule

// File: rtl/csa_sqrt_adder.sv
module csa_sqrt_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int NG  = csa_pkg::grp_count(WIDTH);
    localparam int GW0 = csa_pkg::grp_width(0, WIDTH);

    // Carry entering each group; gc[NG] leaves the top group
    logic [NG:0]      gc;
    // Zero-carry-in ripple results of every group, packed per bit position
    logic [WIDTH-1:0] raw_sum;
    logic [NG-1:0]    raw_co;

    assign gc[0] = cin;

    csa_rca #(.N(GW0)) u_low (
        .op_a  (a[GW0-1:0]),
        .op_b  (b[GW0-1:0]),
        .c_in  (cin),
        .s_out (sum[GW0-1:0]),
        .c_out (gc[1])
    );

    assign raw_sum[GW0-1:0] = sum[GW0-1:0];
    assign raw_co[0]        = gc[1];

    generate
        for (genvar k = 1; k < NG; k++) begin : g_grp
            localparam int LSB = csa_pkg::grp_lsb(k);
            localparam int GW  = csa_pkg::grp_width(k, WIDTH);

            csa_group #(.N(GW)) u_grp (
                .op_a  (a[LSB +: GW]),
                .op_b  (b[LSB +: GW]),
                .c_sel (gc[k]),
                .s_out (sum[LSB +: GW]),
                .c_out (gc[k+1]),
                .raw_s (raw_sum[LSB +: GW]),
                .raw_c (raw_co[k])
            );
        end
    endgenerate

    assign cout = gc[NG];
endmodule

// File: rtl/csa_sqrt_adder_chk.sv
module csa_sqrt_adder_chk #(
    parameter int WIDTH = 16,
    parameter int NG    = csa_pkg::grp_count(WIDTH)
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic [NG:0]      gc,
    input logic [WIDTH-1:0] raw_sum,
    input logic [NG-1:0]    raw_co
);
    localparam int GW0 = csa_pkg::grp_width(0, WIDTH);

    function automatic logic [WIDTH:0] low_mask(input int nbits);
        logic [WIDTH:0] m;
        m = '0;
        for (int i = 0; i <= WIDTH; i++) if (i < nbits) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [WIDTH:0] field(input logic [WIDTH-1:0] v,
                                             input int lsb, input int gw);
        return ({1'b0, v} >> lsb) & low_mask(gw);
    endfunction

    always_comb begin
        logic [WIDTH:0] total;
        logic [WIDTH:0] part;
        logic [WIDTH:0] sel_v;
        logic [WIDTH:0] raw_v;
        int lsb;
        int gw;

        total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        p_total_r1: assert ({cout, sum} == total)
            else $error("R1 total mismatch");

        p_cout_r6: assert (cout == gc[NG])
            else $error("R6 cout is not top group carry");

        part = ({1'b0, a} & low_mask(GW0)) + ({1'b0, b} & low_mask(GW0))
               + {{WIDTH{1'b0}}, cin};
        p_low_grp_r3: assert ({gc[1], sum[GW0-1:0]} == part[GW0:0])
            else $error("R3 low group mismatch");

        for (int k = 1; k < NG; k++) begin
            lsb   = csa_pkg::grp_lsb(k);
            gw    = csa_pkg::grp_width(k, WIDTH);
            part  = ({1'b0, a} & low_mask(lsb + gw)) + ({1'b0, b} & low_mask(lsb + gw))
                    + {{WIDTH{1'b0}}, cin};
            p_chain_r2: assert (gc[k+1] == part[lsb + gw])
                else $error("R2 boundary carry wrong at group %0d", k);

            sel_v = field(sum, lsb, gw) | ({{WIDTH{1'b0}}, gc[k+1]} << gw);
            raw_v = field(raw_sum, lsb, gw) | ({{WIDTH{1'b0}}, raw_co[k]} << gw);
            if (gc[k] == 1'b0) begin
                p_plain_r4: assert (sel_v == raw_v)
                    else $error("R4 plain result not chosen at group %0d", k);
            end else begin
                p_incr_r5: assert (sel_v == ((raw_v + 1'b1) & low_mask(gw + 1)))
                    else $error("R5 incremented result wrong at group %0d", k);
            end
        end
    end
endmodule

bind csa_sqrt_adder csa_sqrt_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a       (a),
    .b       (b),
    .cin     (cin),
    .sum     (sum),
    .cout    (cout),
    .gc      (gc),
    .raw_sum (raw_sum),
    .raw_co  (raw_co)
);

// File: tb/sim_csa_sqrt_adder.sv
module sim_csa_sqrt_adder;
    localparam int W = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic         rst;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         cin;
    logic [W-1:0] sum;
    logic         cout;

    csa_sqrt_adder #(.WIDTH(W)) u0 (
        .a    (a),
        .b    (b),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    typedef struct {
        logic [W-1:0] xa;
        logic [W-1:0] xb;
        logic         xc;
        logic [W:0]   exp;
        int           req;
    } item_t;

    item_t sb_q[$];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    function automatic string rname(input int r);
        case (r)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Driver: apply operands just after a rising edge, queue the expectation
    task automatic drive(input logic [W-1:0] xa, input logic [W-1:0] xb,
                         input logic xc, input int req);
        item_t it;
        @(posedge clk);
        #1;
        a   = xa;
        b   = xb;
        cin = xc;
        it.xa  = xa;
        it.xb  = xb;
        it.xc  = xc;
        it.exp = {1'b0, xa} + {1'b0, xb} + {{W{1'b0}}, xc};
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: results are combinational, due at the next falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_run++;
            if ({cout, sum} !== it.exp) begin
                n_fail++;
                $display("FAIL %s: a=%h b=%h cin=%b actual=%h expected=%h",
                         rname(it.req), it.xa, it.xb, it.xc, {cout, sum}, it.exp);
            end
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL R7: watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int bnd[$];
        int pos;
        int k;
        rst = 1'b1;
        a   = '0;
        b   = '0;
        cin = 1'b0;
        // Reset state: zero inputs give zero outputs (R8)
        drive('0, '0, 1'b0, 8);
        drive('0, '0, 1'b0, 8);
        @(posedge clk);
        rst = 1'b0;

        // R3: low group uses cin directly
        drive(16'h0001, 16'h0000, 1'b1, 3);
        drive(16'h0003, 16'h0000, 1'b1, 3);
        drive(16'h0002, 16'h0001, 1'b1, 3);
        // R4: no carries between groups
        drive(16'h1234, 16'h4321, 1'b0, 4);
        drive(16'h0808, 16'h1010, 1'b0, 4);
        // R5: alternating patterns make every group wrap through the increment
        drive(16'h5555, 16'hAAAA, 1'b1, 5);
        drive(16'h5555, 16'h5555, 1'b1, 5);
        drive(16'hAAAA, 16'hAAAA, 1'b0, 5);
        // R6: all ones plus one
        drive(16'hFFFF, 16'h0000, 1'b1, 6);
        drive(16'hFFFF, 16'h0001, 1'b0, 6);
        drive(16'hFFFF, 16'hFFFF, 1'b1, 6);
        // R8: zero operands
        drive(16'h0000, 16'h0000, 1'b0, 8);

        // R2: group boundaries from the growth rule 2,2,3,4,5,...
        pos = 0;
        k   = 0;
        while (pos < W) begin
            pos += (k < 2) ? 2 : k + 1;
            k++;
            bnd.push_back((pos < W) ? pos : W);
        end
        foreach (bnd[i]) begin
            logic [W:0] ones;
            ones = ({{W{1'b0}}, 1'b1} << bnd[i]) - 1'b1;
            drive(ones[W-1:0], '0, 1'b1, 2);
            drive(ones[W-1:0], {{(W-1){1'b0}}, 1'b1}, 1'b0, 2);
            drive(ones[W-1:0] >> 1, ones[W-1:0] >> 1, 1'b1, 2);
        end

        // R7: operands changed every cycle, result checked in the same cycle
        for (int i = 0; i < 16; i++) begin
            drive(W'(i * 16'h1111), W'(~(i * 16'h0F0F)), i[0], 7);
        end

        // R1: random operands
        for (int i = 0; i < 3000; i++) begin
            drive(W'($urandom), W'($urandom), 1'($urandom), 1);
        end

        repeat (3) @(posedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule